// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block is the digital control for one H-bridge that drives a motor winding. Each cycle it turns a direction input, a two-bit current-level select, a synchronous current-trip flag and a pair of over-temperature flags into four gate enables: high-side and low-side for leg A, and high-side and low-side for leg B. A two-bit threshold code is also decoded for the external comparator reference. All timing comes from one shared cycle counter, so every interval is a parameter in clock cycles.

While the bridge conducts, the trip flag is not looked at for a short blanking window. This rejects turn-on spikes. After the window, a trip turns off only the conducting high-side switch. The opposite low-side switch stays on, so the winding current recirculates and decays slowly. The high-side switch comes back after a fixed off-time whatever the trip flag shows. Any change of direction, and any start from the disabled state, first passes through a dead interval with every switch off. The level code 11 and an over-temperature condition both force every switch off. The over-temperature shutdown holds until a separate release flag is seen.

Top module: `hb_chopper_ctrl`

## Requirements
- R1: While conducting with `phase_i` = 1, exactly `hs_a_o` and `ls_b_o` are on. With `phase_i` = 0, exactly `hs_b_o` and `ls_a_o` are on. No high-side switch is ever on without the low-side switch of the other leg.
- R2: When `trip_i` is high at an edge during conduction after blanking, from the next cycle only the high-side switch is off. The opposite low-side switch stays on (slow decay).
- R3: The slow-decay interval lasts exactly OFF_CYC cycles. The high-side switch is then re-enabled whatever the level of `trip_i`.
- R4: A change of `phase_i` seen at an edge turns all four switches off from the next cycle, during conduction, decay or an ongoing dead interval. A dead interval lasts DEAD_CYC cycles and restarts if `phase_i` changes again. The new pair turns on only after it ends. Every start from the disabled state also passes through a dead interval.
- R5: `thr_sel_o` is a combinational decode of `lvl_i` = {I1,I0}: 00 gives 3 (full), 01 gives 2 (two thirds), 10 gives 1 (one third), 11 gives 0 (off).
- R6: `lvl_i` = 11 at an edge turns all switches off from the next cycle (fast decay). Leaving 11 restarts through a dead interval.
- R7: `ot_over_i` at an edge turns all switches off from the next cycle. They stay off, even after `ot_over_i` falls, until `ot_under_i` is seen high while `ot_over_i` is low. The outputs then restart through a dead interval.
- R8: While `rst_n` is low at an edge, all switches are off from the next cycle.
- R9: For the first BLANK_CYC cycles of each conduction interval, `trip_i` is ignored. With `trip_i` held high, each conduction interval lasts BLANK_CYC+1 cycles.
- R10: The high-side and low-side switch of the same leg are never on in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_i | input | 1 | Synchronous current-trip comparator flag |
| phase_i | input | 1 | Direction select; 1 drives leg A high |
| lvl_i | input | 2 | Current-level select {I1,I0} |
| ot_over_i | input | 1 | Temperature above shutdown point |
| ot_under_i | input | 1 | Temperature below release point |
| hs_a_o | output | 1 | Leg A high-side enable |
| ls_a_o | output | 1 | Leg A low-side enable |
| hs_b_o | output | 1 | Leg B high-side enable |
| ls_b_o | output | 1 | Leg B low-side enable |
| thr_sel_o | output | 2 | Comparator threshold code |

## Verification
The bench builds the controller with OFF_CYC = 12, DEAD_CYC = 4 and BLANK_CYC = 3, instead of defaults that run to thousands of cycles. With these values many full chop periods fit in a short run. Direction reversals can be placed inside the blanking window, inside decay and inside a dead interval that is already running. The held-trip pattern shows the exact on and off run lengths. The counter wrap and saturation boundaries are reached within a few dozen cycles.

// File: rtl/hb_chop_pkg.sv
// Package: shared types for the H-bridge chopper controller.
// Assumes: one bridge per controller instance; gate enables active high.
package hb_chop_pkg;

    // Controller phase of the chopping cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DEAD  = 2'd1,
        ST_ON    = 2'd2,
        ST_DECAY = 2'd3
    } chop_st_t;

    // Threshold codes handed to the comparator reference
    typedef enum logic [1:0] {
        THR_OFF   = 2'd0,
        THR_THIRD = 2'd1,
        THR_TWO3  = 2'd2,
        THR_FULL  = 2'd3
    } thr_code_t;

    // The four gate enables of one bridge
    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gate_t;

    // Width needed to count up to a given value
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/hb_level_decode.sv
// Module: level-select decoder.
// Turns {I1,I0} into a comparator threshold code and a request to force the bridge off.
// Assumes: lvl_i is already synchronous to the controller clock.
module hb_level_decode
    import hb_chop_pkg::*;
(
    input  logic [1:0] lvl_i,
    output logic [1:0] thr_o,
    output logic       off_req_o
);

    thr_code_t thr_c;

    // Map the level pair to a threshold; 11 means bridge off
    always_comb begin
        case (lvl_i)
            2'b00:   thr_c = THR_FULL;
            2'b01:   thr_c = THR_TWO3;
            2'b10:   thr_c = THR_THIRD;
            default: thr_c = THR_OFF;
        endcase
    end

    assign thr_o     = thr_c;
    assign off_req_o = (lvl_i == 2'b11);

endmodule

// File: rtl/hb_therm_latch.sv
// Module: over-temperature hysteresis latch.
// Sets on the over flag and clears only when the under flag is seen with the over flag low.
// Assumes: both flags are synchronous; the over flag wins if both are high.
module hb_therm_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic over_i,
    input  logic under_i,
    output logic hot_o
);

    logic hot_q;

    // Hold the shutdown state between the trip and release points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hot_q <= 1'b0;
        end else if (over_i) begin
            hot_q <= 1'b1;
        end else if (under_i) begin
            hot_q <= 1'b0;
        end
    end

    assign hot_o = hot_q;

endmodule

// File: rtl/hb_span_timer.sv
// Module: shared interval counter.
// Clears on request, otherwise adds one when told; the controller sets all bounds.
// Assumes: the caller never asks to count past 2**W-1.
module hb_span_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // Count cycles spent in the current interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/hb_chop_fsm.sv
// Module: chopping sequencer and gate map.
// Runs the dead, conduct and slow-decay cycle and maps state and direction to gate enables.
// Assumes: dis_i already merges the level-off request and the thermal condition;
//          DEAD_CYC and OFF_CYC are at least 1.
module hb_chop_fsm
    import hb_chop_pkg::*;
#(
    parameter int OFF_CYC   = 5750,
    parameter int DEAD_CYC  = 250,
    parameter int BLANK_CYC = 125,
    parameter int CNT_W     = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trip_i,
    input  logic             phase_i,
    input  logic             dis_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output gate_t            gates_o
);

    localparam logic [CNT_W-1:0] DEAD_LAST = CNT_W'(DEAD_CYC - 1);
    localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_CYC - 1);
    localparam logic [CNT_W-1:0] BLANK_VAL = CNT_W'(BLANK_CYC);

    chop_st_t st_q, st_d;
    logic     dir_q, dir_d;
    logic     flip;
    logic     blank_done;

    assign flip       = (phase_i != dir_q);
    assign blank_done = (cnt_i >= BLANK_VAL);

    // Next state, latched direction and counter control
    always_comb begin
        st_d      = st_q;
        dir_d     = dir_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        if (dis_i) begin
            st_d      = ST_IDLE;
            cnt_clr_o = 1'b1;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    st_d      = ST_DEAD;
                    dir_d     = phase_i;
                    cnt_clr_o = 1'b1;
                end
                ST_DEAD: begin
                    if (flip) begin
                        dir_d     = phase_i;
                        cnt_clr_o = 1'b1;
                    end else if (cnt_i == DEAD_LAST) begin
                        st_d      = ST_ON;
                        cnt_clr_o = 1'b1;
                    end else begin
                        cnt_inc_o = 1'b1;
                    end
                end
                ST_ON: begin
                    if (flip) begin
                        st_d      = ST_DEAD;
                        dir_d     = phase_i;
                        cnt_clr_o = 1'b1;
                    end else if (blank_done && trip_i) begin
                        st_d      = ST_DECAY;
                        cnt_clr_o = 1'b1;
                    end else if (!blank_done) begin
                        cnt_inc_o = 1'b1;
                    end
                end
                default: begin
                    if (flip) begin
                        st_d      = ST_DEAD;
                        dir_d     = phase_i;
                        cnt_clr_o = 1'b1;
                    end else if (cnt_i == OFF_LAST) begin
                        st_d      = ST_ON;
                        cnt_clr_o = 1'b1;
                    end else begin
                        cnt_inc_o = 1'b1;
                    end
                end
            endcase
        end
    end

    // State and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            dir_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            dir_q <= dir_d;
        end
    end

    // Gate map: high side only while conducting, low side in conduct and decay
    always_comb begin
        gates_o = '0;
        if (st_q == ST_ON || st_q == ST_DECAY) begin
            if (dir_q) begin
                gates_o.ls_b = 1'b1;
                gates_o.hs_a = (st_q == ST_ON);
            end else begin
                gates_o.ls_a = 1'b1;
                gates_o.hs_b = (st_q == ST_ON);
            end
        end
    end

endmodule

// File: rtl/hb_chopper_ctrl.sv
// Module: top of the fixed off-time chopper controller for one H-bridge.
// Combines level decode, thermal latch, interval counter and sequencer.
// Assumes: all inputs synchronous to clk; reset synchronous, active low.
module hb_chopper_ctrl
    import hb_chop_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int OFF_CYC   = 46 * CLK_MHZ,
    parameter int DEAD_CYC  = 2 * CLK_MHZ,
    parameter int BLANK_CYC = CLK_MHZ
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_i,
    input  logic       phase_i,
    input  logic [1:0] lvl_i,
    input  logic       ot_over_i,
    input  logic       ot_under_i,
    output logic       hs_a_o,
    output logic       ls_a_o,
    output logic       hs_b_o,
    output logic       ls_b_o,
    output logic [1:0] thr_sel_o
);

    localparam int MAX_A = (OFF_CYC > DEAD_CYC) ? OFF_CYC : DEAD_CYC;
    localparam int MAX_C = (MAX_A > BLANK_CYC) ? MAX_A : BLANK_CYC;
    localparam int CNT_W = cnt_width(MAX_C);

    logic             off_req;
    logic             hot;
    logic             dis;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;
    gate_t            gates;

    hb_level_decode u_lvl (
        .lvl_i     (lvl_i),
        .thr_o     (thr_sel_o),
        .off_req_o (off_req)
    );

    hb_therm_latch u_therm (
        .clk     (clk),
        .rst_n   (rst_n),
        .over_i  (ot_over_i),
        .under_i (ot_under_i),
        .hot_o   (hot)
    );

    // Any shutdown source forces the sequencer idle
    assign dis = off_req | hot | ot_over_i;

    hb_span_timer #(.W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    hb_chop_fsm #(
        .OFF_CYC   (OFF_CYC),
        .DEAD_CYC  (DEAD_CYC),
        .BLANK_CYC (BLANK_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_i    (trip_i),
        .phase_i   (phase_i),
        .dis_i     (dis),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .gates_o   (gates)
    );

    assign hs_a_o = gates.hs_a;
    assign ls_a_o = gates.ls_a;
    assign hs_b_o = gates.hs_b;
    assign ls_b_o = gates.ls_b;

endmodule

// File: rtl/hb_chopper_checks.sv
// Module: property checker bound to the chopper controller.
// Observes ports only; assumes synchronous active-low reset.
module hb_chopper_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       trip_i,
    input logic       phase_i,
    input logic [1:0] lvl_i,
    input logic       ot_over_i,
    input logic       ot_under_i,
    input logic       hs_a_o,
    input logic       ls_a_o,
    input logic       hs_b_o,
    input logic       ls_b_o,
    input logic [1:0] thr_sel_o
);

    logic all_off;
    assign all_off = !hs_a_o && !ls_a_o && !hs_b_o && !ls_b_o;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o)); // R10
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o)); // R10
    AST_HS_A_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        hs_a_o |-> ls_b_o); // R1
    AST_HS_B_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        hs_b_o |-> ls_a_o); // R1
    AST_LVL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i == 2'b11) |=> all_off); // R6
    AST_OT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ot_over_i |=> all_off); // R7
    AST_PHASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != $past(phase_i)) |=> all_off); // R4
    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_a_o) |-> (!$past(hs_b_o) && !$past(ls_a_o))); // R4
    AST_DECAY_KEEPS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hs_a_o) && ($past(lvl_i) != 2'b11) && !$past(ot_over_i)
         && ($past(phase_i) == $past(phase_i, 2))) |-> ls_b_o); // R2
    AST_THR_OFF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i == 2'b11) |-> (thr_sel_o == 2'd0)); // R5

endmodule

bind hb_chopper_ctrl hb_chopper_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_i     (trip_i),
    .phase_i    (phase_i),
    .lvl_i      (lvl_i),
    .ot_over_i  (ot_over_i),
    .ot_under_i (ot_under_i),
    .hs_a_o     (hs_a_o),
    .ls_a_o     (ls_a_o),
    .hs_b_o     (hs_b_o),
    .ls_b_o     (ls_b_o),
    .thr_sel_o  (thr_sel_o)
);

// File: tb/tb_hb_chopper_ctrl.sv
// Bench: behavioural cycle model compared on every falling edge, plus directed checks.
module tb_hb_chopper_ctrl;

    localparam int OFF_N   = 12;
    localparam int DEAD_N  = 4;
    localparam int BLANK_N = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip_i = 1'b0;
    logic       phase_i = 1'b1;
    logic [1:0] lvl_i = 2'b11;
    logic       ot_over_i = 1'b0;
    logic       ot_under_i = 1'b0;
    logic       hs_a_o, ls_a_o, hs_b_o, ls_b_o;
    logic [1:0] thr_sel_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    bit started = 0;

    always #4 clk = ~clk;

    hb_chopper_ctrl #(
        .OFF_CYC   (OFF_N),
        .DEAD_CYC  (DEAD_N),
        .BLANK_CYC (BLANK_N)
    ) dut (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .phase_i(phase_i),
        .lvl_i(lvl_i), .ot_over_i(ot_over_i), .ot_under_i(ot_under_i),
        .hs_a_o(hs_a_o), .ls_a_o(ls_a_o), .hs_b_o(hs_b_o), .ls_b_o(ls_b_o),
        .thr_sel_o(thr_sel_o)
    );

    // Reference model: 0 disabled, 1 dead gap, 2 conducting, 3 slow decay
    int m_mode = 0;
    int m_cnt = 0;
    int m_dir = 1;
    int m_hot = 0;

    always @(posedge clk) begin
        int off_now;
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_dir = 1; m_hot = 0;
        end else begin
            off_now = (lvl_i == 2'b11) || (m_hot != 0) || ot_over_i;
            if (ot_over_i) m_hot = 1;
            else if (ot_under_i) m_hot = 0;
            if (off_now) begin
                m_mode = 0; m_cnt = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_cnt = 0; m_dir = phase_i;
            end else if (phase_i != m_dir) begin
                m_mode = 1; m_cnt = 0; m_dir = phase_i;
            end else if (m_mode == 1) begin
                m_cnt++;
                if (m_cnt == DEAD_N) begin m_mode = 2; m_cnt = 0; end
            end else if (m_mode == 2) begin
                if (m_cnt >= BLANK_N && trip_i) begin m_mode = 3; m_cnt = 0; end
                else if (m_cnt < BLANK_N) m_cnt++;
            end else begin
                m_cnt++;
                if (m_cnt == OFF_N) begin m_mode = 2; m_cnt = 0; end
            end
        end
        started = 1;
    end

    function automatic logic [3:0] model_gates();
        logic [3:0] g = 4'b0000;  // {hs_a, ls_a, hs_b, ls_b}
        if (m_mode == 2) g = (m_dir != 0) ? 4'b1001 : 4'b0110;
        if (m_mode == 3) g = (m_dir != 0) ? 4'b0001 : 4'b0100;
        return g;
    endfunction

    function automatic logic [1:0] model_thr(input logic [1:0] l);
        case (l)
            2'b00: return 2'd3;
            2'b01: return 2'd2;
            2'b10: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic string mode_tag();
        case (m_mode)
            0: return "R6";
            1: return "R4";
            2: return "R1";
            default: return "R2";
        endcase
    endfunction

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        logic [3:0] act;
        if (started && !done) begin
            act = {hs_a_o, ls_a_o, hs_b_o, ls_b_o};
            checks++;
            if (act !== model_gates()) begin
                fails++;
                $display("FAIL %s gates at cycle %0d: actual %b expected %b",
                         mode_tag(), cyc, act, model_gates());
            end
            checks++;
            if (thr_sel_o !== model_thr(lvl_i)) begin
                fails++;
                $display("FAIL R5 threshold: actual %0d expected %0d", thr_sel_o, model_thr(lvl_i));
            end
            if ((hs_a_o && ls_a_o) || (hs_b_o && ls_b_o)) begin
                fails++;
                $display("FAIL R10 leg overlap: actual %b expected no overlap", act);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic expect_gates(input string req, input logic [3:0] exp);
        logic [3:0] act;
        @(negedge clk);
        act = {hs_a_o, ls_a_o, hs_b_o, ls_b_o};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s directed gates: actual %b expected %b", req, act, exp);
        end
        #2;
    endtask

    task automatic expect_thr(input string req, input logic [1:0] exp);
        #1;
        checks++;
        if (thr_sel_o !== exp) begin
            fails++;
            $display("FAIL %s directed threshold: actual %0d expected %0d", req, thr_sel_o, exp);
        end
    endtask

    // Measure one conduction run and the following decay run with trip held high
    task automatic run_lengths(output int on_len, output int off_len);
        on_len = 0; off_len = 0;
        while (!hs_b_o) @(negedge clk);
        while (hs_b_o) begin on_len++; @(negedge clk); end
        while (!hs_b_o && ls_a_o) begin off_len++; @(negedge clk); end
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        int on_len, off_len;
        tick(3);
        expect_gates("R8", 4'b0000);           // R8 reset holds all off
        expect_thr("R5", 2'd0);
        rst_n = 1'b1;
        lvl_i = 2'b00;
        expect_thr("R5", 2'd3);
        tick(10);
        expect_gates("R1", 4'b1001);           // R1 phase high pair
        trip_i = 1'b1; tick(1); trip_i = 1'b0;
        expect_gates("R2", 4'b0001);           // R2 slow decay keeps sink
        tick(20);
        phase_i = 1'b0;                        // R4 reversal from conduction
        tick(2);
        phase_i = 1'b1; tick(1); phase_i = 1'b0; // R4 reversal inside a dead gap
        tick(3);
        trip_i = 1'b1;                          // R9 held trip from the start of conduction
        run_lengths(on_len, off_len);
        checks++;
        if (on_len != BLANK_N + 1) begin
            fails++;
            $display("FAIL R9 on run: actual %0d expected %0d", on_len, BLANK_N + 1);
        end
        checks++;
        if (off_len != OFF_N) begin
            fails++;
            $display("FAIL R3 off run: actual %0d expected %0d", off_len, OFF_N);
        end
        tick(5);
        phase_i = 1'b1;                        // R4 reversal during decay or conduction
        tick(3);
        trip_i = 1'b0;
        tick(12);
        lvl_i = 2'b01; expect_thr("R5", 2'd2);
        tick(2);
        lvl_i = 2'b10; expect_thr("R5", 2'd1);
        tick(2);
        lvl_i = 2'b11; expect_thr("R5", 2'd0);
        tick(1);
        expect_gates("R6", 4'b0000);           // R6 level off forces all off
        lvl_i = 2'b00;
        tick(10);
        expect_gates("R1", 4'b1001);
        ot_over_i = 1'b1; tick(1); ot_over_i = 1'b0;
        tick(10);
        expect_gates("R7", 4'b0000);           // R7 latched off after over clears
        ot_under_i = 1'b1; tick(1); ot_under_i = 1'b0;
        tick(10);
        expect_gates("R7", 4'b1001);           // R7 restart after release
        phase_i = 1'b0;
        tick(10);
        expect_gates("R1", 4'b0110);           // R1 phase low pair
        trip_i = 1'b1;
        tick(40);
        trip_i = 1'b0;
        rst_n = 1'b0;
        tick(1);
        expect_gates("R8", 4'b0000);
        tick(2);
        finish_up();
    end

endmodule